// File: doc/BRIEF.md
# Dual-Port Memory Pattern Tester

This block exercises a two-port synchronous memory of 256 words of 8 bits. Each run writes a chosen data pattern into every word and checks what the memory returns. It then reports whether every compare matched, how many did not, and the first address that failed. A run begins with a one-cycle `start` pulse. The `mode` and `pattern` inputs are sampled at that moment and held until the run ends.

Read data from the memory may arrive late, after a long clock-to-out and a board round trip. For this reason it is first captured by a flop on `cap_clk`. That clock has the same frequency as `clk`, with a delay set outside the block (nominally about 10 ns of capture delay for this class of part). The captured data is then re-registered on `clk`. The expected data and the address run through a delay line of matching length, so each returned word is compared with the value that was requested for it.

The control is a five-state machine:
- IDLE goes to FILL on an accepted start in the single-read modes, and to WRDRD on an accepted start in the read-during-write mode.
- FILL goes to READ after the last address.
- READ and WRDRD go to DRAIN after the last address.
- DRAIN goes back to IDLE once the compare pipeline has emptied, and raises `done` at that point.

Top module: `sptc_top`

## Requirements
- R1: Every access phase issues one command per cycle, on addresses 0, 1, … 255 in ascending order, with no gap between phases.
- R2: Pattern codes are as follows. 0 gives 0x00 for every word. 1 gives 0xFF. 2 gives a checkerboard: 0x55 at even addresses and 0xAA at odd ones. 3 gives the low 8 address bits as data.
- R3: Mode code 0 is the single-port mode. A FILL phase writes the pattern through port A. A READ phase then reads it back through port A only, and port B stays disabled.
- R4: Mode code 1 is the dual-read mode. It has the same FILL phase as mode 0. In READ, both ports read the same address in the same cycle, and each port's data is compared separately, so a bad word counts two errors.
- R5: Mode code 2 is the read-during-write mode, with 256 cycles in WRDRD and no separate fill. Each cycle, port A writes the pattern word while port B reads the same address. Port B's data is compared with the word being written.
- R6: After the last command cycle there are three idle cycles with `busy` high. In the fourth cycle `done` is high, `busy` is low, and the results are final.
- R7: `err_count` equals the number of mismatching compares in the run and is cleared by an accepted start. `pass` is high exactly when `done` is high and `err_count` is zero.
- R8: `err_count` saturates at 2^ERR_W−1 and never wraps.
- R9: `first_err_addr` holds the address of the first mismatching compare, and `first_err_valid` marks that one exists. Both are cleared by an accepted start.
- R10: A `start` pulse while `busy` is high is ignored. The command sequence of the running run is unchanged.
- R11: Mode code 3 runs exactly like mode code 0.
- R12: After reset, `busy`, `done`, `pass`, `first_err_valid`, `a_en` and `b_en` are low, and `err_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main test clock |
| cap_clk | input | 1 | Delayed copy of clk for read capture |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run request |
| mode | input | 2 | Access mode code (R3, R4, R5, R11) |
| pattern | input | 2 | Pattern code (R2) |
| a_en | output | 1 | Port A access enable |
| a_we | output | 1 | Port A write enable |
| a_addr | output | 8 | Port A address |
| a_wdata | output | 8 | Port A write data |
| a_rdata | input | 8 | Port A read data |
| b_en | output | 1 | Port B read enable |
| b_addr | output | 8 | Port B address |
| b_rdata | input | 8 | Port B read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished; held until next start |
| pass | output | 1 | done with no error |
| err_count | output | 16 | Saturating mismatch count |
| first_err_valid | output | 1 | A mismatch has been recorded |
| first_err_addr | output | 8 | Address of the first mismatch |

## Verification
A wrong state or a wrong address counter shows at the memory command ports in the very next cycle. The bench's cycle model therefore catches a skipped, repeated or misordered address, or a missing phase, at the cycle it happens. A delay line that is out of step with the capture path does not show at the commands. It shows only when the run finishes: good words are counted as errors, or a fault is reported at a neighbouring address. The bench injects stuck-at bits at known addresses and checks the exact count and address when `done` rises, three cycles after the last command.

// File: rtl/sptc_pkg.sv
package sptc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_READ,
        ST_WRDRD,
        ST_DRAIN
    } sptc_state_e;

    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_DUAL   = 2'd1;
    localparam logic [1:0] MODE_WRDRD  = 2'd2;

    localparam logic [1:0] PAT_ZERO  = 2'd0;
    localparam logic [1:0] PAT_ONE   = 2'd1;
    localparam logic [1:0] PAT_CHECK = 2'd2;
    localparam logic [1:0] PAT_ADDR  = 2'd3;
endpackage

// File: rtl/sptc_patgen.sv
module sptc_patgen #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic [1:0]    sel,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    import sptc_pkg::*;

    logic [DW-1:0] check_word;
    logic [DW-1:0] addr_word;

    // Checkerboard: even bits set on even addresses, odd bits on odd ones.
    // Address-as-data: low address bits, zero-extended.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign check_word[i] = ((i % 2) == 0) ^ addr[0];
        if (i < AW) begin : g_addr
            assign addr_word[i] = addr[i];
        end else begin : g_pad
            assign addr_word[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            PAT_ZERO:  data = '0;
            PAT_ONE:   data = '1;
            PAT_CHECK: data = check_word;
            default:   data = addr_word;
        endcase
    end
endmodule

// File: rtl/sptc_capture.sv
module sptc_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          cap_clk,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] cap_q;
    logic [DW-1:0] ret_q;

    // Late-phase capture of the returning data
    always_ff @(posedge cap_clk) begin
        cap_q <= din;
    end

    // Hand-over into the main clock domain
    always_ff @(posedge clk) begin
        ret_q <= cap_q;
    end

    assign dout = ret_q;
endmodule

// File: rtl/sptc_delay.sv
module sptc_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/sptc_checker.sv
module sptc_checker #(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             vld_a,
    input  logic             vld_b,
    input  logic [DW-1:0]    exp_data,
    input  logic [AW-1:0]    cmp_addr,
    input  logic [DW-1:0]    rd_a,
    input  logic [DW-1:0]    rd_b,
    output logic [ERR_W-1:0] err_count,
    output logic             first_valid,
    output logic [AW-1:0]    first_addr
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic             miss_a, miss_b;
    logic [1:0]       inc;
    logic [ERR_W:0]   sum;
    logic [ERR_W-1:0] err_q;
    logic             fv_q;
    logic [AW-1:0]    fa_q;

    assign miss_a = vld_a && (rd_a != exp_data);
    assign miss_b = vld_b && (rd_b != exp_data);
    assign inc    = {1'b0, miss_a} + {1'b0, miss_b};
    assign sum    = {1'b0, err_q} + {{(ERR_W-1){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            err_q <= '0;
            fv_q  <= 1'b0;
            fa_q  <= '0;
        end else begin
            err_q <= sum[ERR_W] ? ERR_MAX : sum[ERR_W-1:0];
            if ((miss_a || miss_b) && !fv_q) begin
                fv_q <= 1'b1;
                fa_q <= cmp_addr;
            end
        end
    end

    assign err_count   = err_q;
    assign first_valid = fv_q;
    assign first_addr  = fa_q;

    assert_err_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> err_count >= $past(err_count));

    assert_err_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == ERR_MAX && !clear) |=> err_count == ERR_MAX);

    assert_first_implies_errors_R9: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> err_count != '0);
endmodule

// File: rtl/sptc_top.sv
module sptc_top #(
    parameter int AW     = 8,
    parameter int DW     = 8,
    parameter int ERR_W  = 16,
    parameter int RD_LAT = 1
) (
    input  logic             clk,
    input  logic             cap_clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [1:0]       pattern,
    output logic             a_en,
    output logic             a_we,
    output logic [AW-1:0]    a_addr,
    output logic [DW-1:0]    a_wdata,
    input  logic [DW-1:0]    a_rdata,
    output logic             b_en,
    output logic [AW-1:0]    b_addr,
    input  logic [DW-1:0]    b_rdata,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic [ERR_W-1:0] err_count,
    output logic             first_err_valid,
    output logic [AW-1:0]    first_err_addr
);
    import sptc_pkg::*;

    localparam int            LAT     = RD_LAT + 1;
    localparam int            CNT_W   = $clog2(LAT + 1);
    localparam int            PIPE_W  = 2 + DW + AW;
    localparam logic [AW-1:0] LAST    = '1;
    localparam logic [CNT_W-1:0] DRAIN_END = CNT_W'(LAT);

    sptc_state_e     state_q, state_d;
    logic [AW-1:0]   addr_q;
    logic [CNT_W-1:0] drain_q;
    logic [1:0]      mode_q, pat_q;
    logic            done_q;
    logic            accept;
    logic [DW-1:0]   pat_word;
    logic            vld_a, vld_b;

    assign accept = (state_q == ST_IDLE) && start;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (mode == MODE_WRDRD) ? ST_WRDRD : ST_FILL;
            ST_FILL:  if (addr_q == LAST) state_d = ST_READ;
            ST_READ:  if (addr_q == LAST) state_d = ST_DRAIN;
            ST_WRDRD: if (addr_q == LAST) state_d = ST_DRAIN;
            ST_DRAIN: if (drain_q == DRAIN_END) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and run context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            drain_q <= '0;
            mode_q  <= MODE_SINGLE;
            pat_q   <= PAT_ZERO;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= '0;
                mode_q <= mode;
                pat_q  <= pattern;
                done_q <= 1'b0;
            end else if (state_q == ST_FILL || state_q == ST_READ || state_q == ST_WRDRD) begin
                addr_q <= addr_q + 1'b1;
            end
            drain_q <= (state_q == ST_DRAIN) ? drain_q + 1'b1 : '0;
            if (state_q == ST_DRAIN && state_d == ST_IDLE) done_q <= 1'b1;
        end
    end

    sptc_patgen #(.AW(AW), .DW(DW)) u_patgen (
        .sel  (pat_q),
        .addr (addr_q),
        .data (pat_word)
    );

    // Command and compare-valid outputs
    always_comb begin
        a_en    = 1'b0;
        a_we    = 1'b0;
        b_en    = 1'b0;
        vld_a   = 1'b0;
        unique case (state_q)
            ST_FILL:  begin a_en = 1'b1; a_we = 1'b1; end
            ST_READ:  begin a_en = 1'b1; vld_a = 1'b1; b_en = (mode_q == MODE_DUAL); end
            ST_WRDRD: begin a_en = 1'b1; a_we = 1'b1; b_en = 1'b1; end
            default:  ;
        endcase
        vld_b   = b_en;
        a_addr  = addr_q;
        b_addr  = addr_q;
        a_wdata = a_we ? pat_word : '0;
        busy    = (state_q != ST_IDLE);
        done    = done_q;
    end

    // Read return path: delayed-phase capture, then retime
    logic [1:0][DW-1:0] raw_rd, ret_rd;
    assign raw_rd[0] = a_rdata;
    assign raw_rd[1] = b_rdata;

    for (genvar p = 0; p < 2; p++) begin : g_port
        sptc_capture #(.DW(DW)) u_cap (
            .clk     (clk),
            .cap_clk (cap_clk),
            .din     (raw_rd[p]),
            .dout    (ret_rd[p])
        );
    end

    // Expected-data alignment matching the return path
    logic [PIPE_W-1:0] pipe_in, pipe_out;
    assign pipe_in = {vld_a, vld_b, pat_word, addr_q};

    sptc_delay #(.W(PIPE_W), .DEPTH(LAT)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pipe_in),
        .dout  (pipe_out)
    );

    sptc_checker #(.AW(AW), .DW(DW), .ERR_W(ERR_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .vld_a       (pipe_out[PIPE_W-1]),
        .vld_b       (pipe_out[PIPE_W-2]),
        .exp_data    (pipe_out[AW +: DW]),
        .cmp_addr    (pipe_out[AW-1:0]),
        .rd_a        (ret_rd[0]),
        .rd_b        (ret_rd[1]),
        .err_count   (err_count),
        .first_valid (first_err_valid),
        .first_addr  (first_err_addr)
    );

    assign pass = done_q && (err_count == '0);

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && $past(a_en)) |-> a_addr == AW'($past(a_addr) + 1'b1));

    assert_done_from_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q) == ST_DRAIN);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q) && $stable(pat_q));

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !a_en && !b_en);
endmodule

// File: tb/sptc_top_tb_top.sv
module sptc_top_tb_top;
    logic clk = 1'b0;
    logic cap_clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] pattern = 2'd0;
    logic a_en, a_we, b_en;
    logic [7:0] a_addr, a_wdata, b_addr;
    logic [7:0] a_rdata = 8'h00;
    logic [7:0] b_rdata = 8'h00;
    logic busy, done, pass, first_err_valid;
    logic [15:0] err_count;
    logic [7:0] first_err_addr;

    logic start_s = 1'b0;
    logic s_a_en, s_a_we, s_b_en, s_busy, s_done, s_pass, s_fv;
    logic [7:0] s_a_addr, s_a_wdata, s_b_addr, s_fa;
    logic [3:0] s_err;

    int checks = 0;
    int failures = 0;

    logic [7:0] mem [256];
    logic [7:0] fault_addr = 8'h00;
    logic [7:0] fault_mask = 8'h00;

    always #4 clk = ~clk;
    always @(posedge clk) begin
        #3 cap_clk = 1'b1;
        #4 cap_clk = 1'b0;
    end

    sptc_top dut_i (
        .clk(clk), .cap_clk(cap_clk), .rst_n(rst_n), .start(start),
        .mode(mode), .pattern(pattern),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_addr(b_addr), .b_rdata(b_rdata),
        .busy(busy), .done(done), .pass(pass), .err_count(err_count),
        .first_err_valid(first_err_valid), .first_err_addr(first_err_addr)
    );

    sptc_top #(.ERR_W(4)) dut_sat_i (
        .clk(clk), .cap_clk(cap_clk), .rst_n(rst_n), .start(start_s),
        .mode(2'd1), .pattern(2'd0),
        .a_en(s_a_en), .a_we(s_a_we), .a_addr(s_a_addr), .a_wdata(s_a_wdata), .a_rdata(8'hFF),
        .b_en(s_b_en), .b_addr(s_b_addr), .b_rdata(8'hFF),
        .busy(s_busy), .done(s_done), .pass(s_pass), .err_count(s_err),
        .first_err_valid(s_fv), .first_err_addr(s_fa)
    );

    // Behavioural two-port memory, one-cycle read, write-through on collision
    function automatic logic [7:0] rd_word(input logic [7:0] ad);
        return mem[ad] | ((ad == fault_addr) ? fault_mask : 8'h00);
    endfunction

    always @(posedge clk) begin
        if (a_en && a_we) mem[a_addr] <= a_wdata;
        if (a_en && !a_we) a_rdata <= rd_word(a_addr);
        if (b_en) begin
            if (a_en && a_we && a_addr == b_addr)
                b_rdata <= a_wdata | ((b_addr == fault_addr) ? fault_mask : 8'h00);
            else
                b_rdata <= rd_word(b_addr);
        end
    end

    function automatic logic [7:0] pat_of(input logic [1:0] p, input int ad);
        case (p)
            2'd0: return 8'h00;
            2'd1: return 8'hFF;
            2'd2: return (ad % 2 == 0) ? 8'h55 : 8'hAA;
            default: return 8'(ad);
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One run, compared against the cycle model on every clock
    task automatic run(input logic [1:0] m, input logic [1:0] p,
                       input logic [7:0] faddr, input logic [7:0] fmask,
                       input bit poke_busy, input string tag);
        int n;
        int nerr;
        int ports;
        logic [7:0] fw;
        fault_addr = faddr;
        fault_mask = fmask;
        n     = (m == 2'd2) ? 256 : 512;
        ports = (m == 2'd1) ? 2 : 1;
        fw    = pat_of(p, faddr);
        nerr  = ((fw | fmask) != fw) ? ports : 0;
        @(negedge clk);
        mode = m; pattern = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < n + 4; c++) begin
            logic e_aen, e_awe, e_ben;
            logic [7:0] e_aad, e_wd, e_bad;
            logic [25:0] act, exp;
            if (c > 0) @(negedge clk);
            if (poke_busy && c == 12) begin start = 1'b1; mode = 2'd2; pattern = 2'd1; end
            if (poke_busy && c == 13) start = 1'b0;
            e_aen = 0; e_awe = 0; e_ben = 0; e_aad = 0; e_wd = 0; e_bad = 0;
            if (c < n) begin
                e_aen = 1;
                if (m == 2'd2) begin
                    e_awe = 1; e_aad = 8'(c); e_wd = pat_of(p, c); e_ben = 1; e_bad = 8'(c);
                end else if (c < 256) begin
                    e_awe = 1; e_aad = 8'(c); e_wd = pat_of(p, c);
                end else begin
                    e_aad = 8'(c - 256);
                    e_ben = (m == 2'd1);
                    e_bad = e_ben ? 8'(c - 256) : 8'h00;
                end
            end
            act = {a_en, a_we, a_en ? a_addr : 8'h00, a_we ? a_wdata : 8'h00,
                   b_en, b_en ? b_addr : 8'h00};
            exp = {e_aen, e_awe, e_aad, e_wd, e_ben, e_bad};
            chk(act == exp, tag, "command R1 R2 R3 R4 R5 R10", act, exp);
            if (c == 0) begin
                chk(done == 0 && err_count == 0 && !first_err_valid, "R7", "clear on start",
                    {done, first_err_valid, err_count}, 0);
            end
            if (c >= n && c < n + 3) chk(busy && !done, "R6", "drain", {busy, done}, 2'b10);
        end
        chk(done && !busy, "R6", "done after drain", {done, busy}, 2'b10);
        chk(err_count == 16'(nerr), "R7", "error count", err_count, nerr);
        chk(pass == (nerr == 0), "R7", "pass flag", pass, nerr == 0);
        chk(first_err_valid == (nerr != 0), "R9", "first valid", first_err_valid, nerr != 0);
        if (nerr != 0) chk(first_err_addr == faddr, "R9", "first address", first_err_addr, faddr);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pass && !first_err_valid && !a_en && !b_en && err_count == 0,
            "R12", "reset state", {busy, done, pass, first_err_valid, a_en, b_en}, 0);

        run(2'd0, 2'd2, 8'h37, 8'h01, 1'b0, "R3");
        run(2'd1, 2'd3, 8'h80, 8'h40, 1'b1, "R4");
        run(2'd2, 2'd0, 8'hFF, 8'h10, 1'b0, "R5");
        run(2'd2, 2'd1, 8'h10, 8'hFF, 1'b0, "R2");
        run(2'd3, 2'd0, 8'h00, 8'h00, 1'b0, "R11");
        run(2'd1, 2'd2, 8'h00, 8'h00, 1'b0, "R4");

        // R8: every compare fails on the narrow-counter instance
        @(negedge clk);
        start_s = 1'b1;
        @(negedge clk);
        start_s = 1'b0;
        for (int k = 0; k < 1000 && !s_done; k++) @(negedge clk);
        chk(s_done, "R8", "saturation run done", s_done, 1);
        chk(s_err == 4'hF, "R8", "saturated count", s_err, 4'hF);
        chk(s_fv && s_fa == 8'h00 && !s_pass, "R9", "first fail at address 0",
            {s_fv, s_pass, s_fa}, 10'h200);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule